// File: doc/BRIEF.md
# Double-Buffered Serial Frame Transmitter

This block serializes bytes onto a single asynchronous-style serial line. A host hands it one byte at a time through a simple write strobe. The byte lands in a one-entry holding register. From there it moves into a frame shifter as soon as the shifter can start a new frame: at once if the line is idle, or on the very cycle the previous frame's final stop bit ends. Because of this handoff, a host that keeps the holding register filled gets frames with no idle gap between them.

Each frame is a low start bit, then 5 to 8 data bits least significant bit first, then one or two high stop bits. The line rests high. The bit rate comes from an internal divisor, with a double-speed option that halves the bit time. A synchronous mode instead advances the bit stream on rising edges of an external clock input, sampled through a synchronizer. Two status outputs tell the host whether the holding register can take a write and whether the line has gone quiet after the last frame. Rate, mode and format are set up while the block is idle.

Top module: `sertx_top`

## Requirements
- R1: While reset is asserted and just after it, tx_out is 1, buf_empty is 1 and tx_done is 0.
- R2: A frame is one start bit at 0, then the data bits least significant bit first, then the stop bit(s) at 1; while enabled and not sending, tx_out is 1.
- R3: cfg_width value w (0 to 3) selects 5+w data bits; data bits at positions 5+w and above are ignored, so the stop bit follows directly after bit 4+w.
- R4: cfg_two_stop=1 gives two stop bits and cfg_two_stop=0 gives one.
- R5: With cfg_sync=0 and cfg_fast=0, every bit lasts 16*(cfg_div+1) clock cycles.
- R6: With cfg_sync=0 and cfg_fast=1, every bit lasts 8*(cfg_div+1) clock cycles.
- R7: With cfg_sync=1, a frame starts and each bit advances only on a synchronized rising edge of ext_clk, so every bit lasts one ext_clk period.
- R8: A byte accepted while the shifter is idle (asynchronous mode) makes buf_empty 0 on the next cycle; it moves to the shifter one cycle later, when buf_empty returns to 1 and the start bit appears.
- R9: A byte held while a frame is in flight starts its start bit in the cycle right after the last stop bit ends, with no idle cycle between the frames.
- R10: A write while buf_empty is 0 is dropped: the held byte is unchanged and no extra frame is sent.
- R11: tx_done becomes 1 when the last stop bit ends with nothing held, stays 1 until the next accepted write, and stays 0 between back-to-back frames.
- R12: While cfg_en is 0, tx_out is 1 and writes are ignored; dropping cfg_en mid-frame abandons the frame and empties the holding register, and tx_done goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Transmitter enable |
| cfg_width | input | 2 | Character size code, 5+value data bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_div | input | 12 | Bit-rate divisor |
| cfg_fast | input | 1 | Double-speed select, asynchronous mode |
| cfg_sync | input | 1 | 1 takes the bit timing from ext_clk |
| ext_clk | input | 1 | External bit clock for synchronous mode |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| tx_out | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register can take a write |
| tx_done | output | 1 | Last frame finished and nothing is waiting |

## Verification
The main function is driven with a single byte from idle, with back-to-back bytes at two stop bits, with all-zero data at the narrowest character size, and with data whose upper bits must be dropped. The all-zero narrow case separates correct masking from a stop bit that lands too late. The back-to-back case separates a gap-free handoff from one that adds an idle cycle, because the measured distance between the two start edges must match the frame length exactly. Start-bit widths measured at two divisors, with and without double speed and under an external clock, separate the three bit-timing sources.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W  = 8;
  localparam int DIV_W   = 12;
  localparam int FRAME_W = DATA_W + 4;   // start + data + two stops, one spare
  localparam int CNT_W   = DIV_W + 5;    // holds 16*(2^DIV_W)
  localparam int LEN_W   = 4;

  // number of data bits for a width code
  function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] wcode);
    return LEN_W'(5) + LEN_W'(wcode);
  endfunction

  // total bits in a frame: start + data + stops
  function automatic logic [LEN_W-1:0] frame_len(input logic [1:0] wcode,
                                                  input logic       two_stop);
    return char_bits(wcode) + LEN_W'(2) + LEN_W'(two_stop);
  endfunction

  // system clocks per bit in asynchronous mode
  function automatic logic [CNT_W-1:0] bit_period(input logic [DIV_W-1:0] div,
                                                   input logic             fast);
    logic [CNT_W-1:0] base;
    base = CNT_W'(div) + CNT_W'(1);
    return fast ? (base << 3) : (base << 4);
  endfunction

  // frame image, bit 0 first on the line; bits above the character are 1
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [DATA_W-1:0] d,
                                                     input logic [1:0]        wcode);
    logic [DATA_W-1:0] keep;
    keep = {DATA_W{1'b1}} >> (2'd3 - wcode);
    return {3'b111, (d & keep) | ~keep, 1'b0};
  endfunction

endpackage

// File: rtl/sertx_rate.sv
module sertx_rate
  import sertx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic             sync,
  input  logic [DIV_W-1:0] div,
  input  logic             fast,
  input  logic             ext_clk,
  output logic             bit_tick
);

  logic [SYNC_STAGES:0] ext_sh;
  logic                 ext_rise;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     limit;
  logic                 async_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];

  assign limit      = bit_period(div, fast) - CNT_W'(1);
  assign async_tick = run && !sync && (cnt == limit);

  // counter rests at zero while idle so every bit is exactly one period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!en || !run || sync)    cnt <= '0;
    else if (cnt == limit)           cnt <= '0;
    else                             cnt <= cnt + CNT_W'(1);
  end

  assign bit_tick = en && (sync ? ext_rise : async_tick);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              wr_accept
);

  assign wr_accept = en && wr_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_accept) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_tick,
  input  logic              sync,
  input  logic [1:0]        wcode,
  input  logic              two_stop,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  output logic              take,
  output logic              busy,
  output logic              frame_end,
  output logic              line
);

  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;
  logic               idle_start;

  assign frame_end  = busy && bit_tick && (left == LEN_W'(1));
  assign idle_start = !busy && (!sync || bit_tick);
  assign take       = en && hold_full && (idle_start || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (!en) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      shreg <= pack_frame(hold_data, wcode);
      left  <= frame_len(wcode, two_stop);
    end else if (frame_end) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (busy && bit_tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - LEN_W'(1);
    end
  end

  assign line = busy ? shreg[0] : 1'b1;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_two_stop,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_fast,
  input  logic              cfg_sync,
  input  logic              ext_clk,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_out,
  output logic              buf_empty,
  output logic              tx_done
);

  // internal events, named for the checker
  logic              bit_tick;
  logic              busy;
  logic              load_evt;
  logic              frame_end;
  logic              wr_accept;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              line;
  logic              done_q;

  sertx_rate #(.SYNC_STAGES(SYNC_STAGES)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .run      (busy),
    .sync     (cfg_sync),
    .div      (cfg_div),
    .fast     (cfg_fast),
    .ext_clk  (ext_clk),
    .bit_tick (bit_tick)
  );

  sertx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (load_evt),
    .full      (hold_full),
    .data      (hold_data),
    .wr_accept (wr_accept)
  );

  sertx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .bit_tick  (bit_tick),
    .sync      (cfg_sync),
    .wcode     (cfg_width),
    .two_stop  (cfg_two_stop),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (load_evt),
    .busy      (busy),
    .frame_end (frame_end),
    .line      (line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       done_q <= 1'b0;
    else if (!cfg_en)                 done_q <= 1'b0;
    else if (wr_accept)               done_q <= 1'b0;
    else if (frame_end && !hold_full) done_q <= 1'b1;
  end

  assign tx_out    = cfg_en ? line : 1'b1;
  assign buf_empty = !hold_full;
  assign tx_done   = done_q;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic tx_out,
  input logic buf_empty,
  input logic tx_done,
  input logic busy,
  input logic load_evt,
  input logic frame_end,
  input logic wr_accept
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !busy) |-> tx_out);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!cfg_en || !tx_out));

  assert_handoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> buf_empty);

  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && frame_end && !buf_empty) |-> load_evt);

  assert_keep_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !buf_empty && !load_evt) |=> !buf_empty);

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && tx_done && !wr_accept) |=> tx_done);

  assert_done_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> buf_empty);

  assert_off_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> tx_out);

  assert_off_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (buf_empty && !tx_done));

endmodule

bind sertx_top sertx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_en    (cfg_en),
  .tx_out    (tx_out),
  .buf_empty (buf_empty),
  .tx_done   (tx_done),
  .busy      (busy),
  .load_evt  (load_evt),
  .frame_end (frame_end),
  .wr_accept (wr_accept)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;

  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_width = 2'd3;
  logic        cfg_two_stop = 1'b0;
  logic [11:0] cfg_div = 12'd0;
  logic        cfg_fast = 1'b0;
  logic        cfg_sync = 1'b0;
  logic        ext_clk = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        tx_out;
  logic        buf_empty;
  logic        tx_done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_fall = 0;
  logic sync_run = 1'b0;

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_width(cfg_width),
    .cfg_two_stop(cfg_two_stop), .cfg_div(cfg_div), .cfg_fast(cfg_fast),
    .cfg_sync(cfg_sync), .ext_clk(ext_clk), .wr_valid(wr_valid),
    .wr_data(wr_data), .tx_out(tx_out), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog all requirements act=%0d exp=<%0d cycles", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // external bit clock: one rising edge every 10 system cycles
  initial begin
    forever begin
      repeat (5) @(negedge clk);
      if (sync_run) ext_clk = ~ext_clk;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_low();
    int guard = 0;
    while (tx_out !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // sample a frame at bit centres, starting from the first low sample
  task automatic recv(input string req, input int n, input int stops,
                      input int per, input logic [7:0] exp);
    logic [7:0] got = 8'h00;
    wait_low();
    last_fall = cyc;
    repeat (per / 2) @(negedge clk);
    chk(req, "start bit", int'(tx_out), 0);
    for (int i = 0; i < n; i++) begin
      repeat (per) @(negedge clk);
      got[i] = tx_out;
    end
    chk(req, "data", int'(got), int'(exp));
    for (int s = 0; s < stops; s++) begin
      repeat (per) @(negedge clk);
      chk(req, "stop bit", int'(tx_out), 1);
    end
  endtask

  task automatic low_len(output int len);
    len = 0;
    wait_low();
    while (tx_out === 1'b0 && len < 100000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic count_low(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b1) lows++;
    end
  endtask

  task automatic wait_done();
    int guard = 0;
    while (tx_done !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "tx_out in reset", int'(tx_out), 1);
    chk("R1", "buf_empty in reset", int'(buf_empty), 1);
    chk("R1", "tx_done in reset", int'(tx_done), 0);
    rst_n = 1'b1;
    cfg_en = 1'b1;
    @(negedge clk);
    chk("R1", "tx_out after reset", int'(tx_out), 1);
    chk("R2", "idle line high", int'(tx_out), 1);
  endtask

  task automatic t_single();
    cfg_width = 2'd3; cfg_two_stop = 1'b0; cfg_div = 12'd0;
    put(8'hA5);
    chk("R8", "buf_empty after write", int'(buf_empty), 0);
    @(negedge clk);
    chk("R8", "buf_empty after handoff", int'(buf_empty), 1);
    chk("R8", "start bit after handoff", int'(tx_out), 0);
    recv("R2", 8, 1, 16, 8'hA5);
    repeat (16) @(negedge clk);
    chk("R11", "tx_done after last stop", int'(tx_done), 1);
    chk("R2", "line back high", int'(tx_out), 1);
    put(8'h5A);
    chk("R11", "tx_done cleared by write", int'(tx_done), 0);
    recv("R2", 8, 1, 16, 8'h5A);
    wait_done();
  endtask

  task automatic t_width();
    cfg_width = 2'd0;
    put(8'h00);
    recv("R3", 5, 1, 16, 8'h00);   // stop must follow bit 4
    wait_done();
    cfg_width = 2'd1;
    put(8'hC3);
    recv("R3", 6, 1, 16, 8'h03);
    wait_done();
    cfg_width = 2'd2;
    put(8'h80);
    recv("R3", 7, 1, 16, 8'h00);
    wait_done();
    cfg_width = 2'd3;
  endtask

  task automatic t_b2b();
    int lows;
    int f1;
    cfg_two_stop = 1'b1;
    put(8'h3C);
    @(negedge clk);
    f1 = cyc;                         // first low sample of frame 1
    put(8'h81);
    chk("R9", "second byte held", int'(buf_empty), 0);
    put(8'hFF);                       // buffer full: must be dropped
    chk("R10", "still full after extra write", int'(buf_empty), 0);
    recv("R4", 8, 2, 16, 8'h3C);
    chk("R11", "tx_done low between frames", int'(tx_done), 0);
    recv("R4", 8, 2, 16, 8'h81);
    chk("R9", "start-to-start distance", last_fall - f1, 11 * 16);
    repeat (16) @(negedge clk);
    chk("R11", "tx_done after back-to-back", int'(tx_done), 1);
    count_low(12 * 16, lows);
    chk("R10", "no frame from dropped write", lows, 0);
    cfg_two_stop = 1'b0;
  endtask

  task automatic t_rate();
    int len;
    cfg_div = 12'd2; cfg_fast = 1'b0;
    put(8'h01);
    low_len(len);
    chk("R5", "bit length divisor 2", len, 48);
    wait_done();
    cfg_fast = 1'b1;
    put(8'h01);
    low_len(len);
    chk("R6", "bit length double speed", len, 24);
    wait_done();
    put(8'h5A);
    recv("R6", 8, 1, 24, 8'h5A);
    wait_done();
    cfg_div = 12'd0; cfg_fast = 1'b0;
  endtask

  task automatic t_sync();
    int len;
    cfg_sync = 1'b1;
    sync_run = 1'b1;
    put(8'h01);
    low_len(len);
    chk("R7", "bit length from ext_clk", len, 10);
    wait_done();
    put(8'h96);
    recv("R7", 8, 1, 10, 8'h96);
    wait_done();
    sync_run = 1'b0;
    cfg_sync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_disable();
    int lows;
    cfg_en = 1'b0;
    @(negedge clk);
    chk("R12", "tx_done cleared when disabled", int'(tx_done), 0);
    put(8'h00);
    chk("R12", "write ignored while disabled", int'(buf_empty), 1);
    count_low(40, lows);
    chk("R12", "line high while disabled", lows, 0);
    cfg_en = 1'b1;
    put(8'h00);
    repeat (3 * 16) @(negedge clk);
    chk("R12", "mid-frame data low", int'(tx_out), 0);
    cfg_en = 1'b0;
    #1;
    chk("R12", "line high at disable", int'(tx_out), 1);
    @(negedge clk);
    chk("R12", "buffer empty after abort", int'(buf_empty), 1);
    cfg_en = 1'b1;
    count_low(12 * 16, lows);
    chk("R12", "aborted frame not resumed", lows, 0);
    chk("R12", "no tx_done after abort", int'(tx_done), 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_width();
    t_b2b();
    t_rate();
    t_sync();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule